// File: doc/BRIEF.md
# Dynamic element matching rotation controller

This block produces the routing selects for a chain of dynamic current-divider stages in a current-steering DAC. Each stage has four nearly equal source currents and four output roles. Positions 0 and 1 are summed into the stage's larger bit. Position 2 drives a bit switch directly. Position 3 feeds the next stage. The controller rotates which source fills which role, so that over a full period every source spends the same time in every role. Mismatch between the sources then averages out once the analog output is filtered.

Each stage holds a four-bit one-hot shift register that rotates circularly. A crossbar decoder turns it into a 4x4 one-hot select matrix. The block runs on its own free-running interchange clock and never uses sample or data timing. When `DIV_LOG2` is zero, all stages share one rotation phase. When it is larger, stage s advances once every 2^(s·DIV_LOG2) enabled clocks, and its rotation stays uniform over its own longer period.

Top module: `dem_rotation_ctrl`

## Requirements
- R1: A clock edge with `rst_n` low puts every stage in state 0, the identity mapping: source i drives position i. Select bit `s*16 + src*4 + pos` is high when source `src` drives position `pos` of stage `s`.
- R2: In every cycle, each stage's 4x4 select matrix has exactly one high bit in every source row and exactly one in every position column.
- R3: In state k, source i drives position (i+k) mod 4. Each advance of a stage moves every source from position p to position (p+1) mod 4, so the mapping repeats every four advances.
- R4: While `en` is low, all selects of all stages hold their values.
- R5: With `DIV_LOG2` = 0, every stage advances on every enabled clock, and all stages show the same mapping.
- R6: With `DIV_LOG2` = D > 0, stage s advances on enabled clocks number 0, 2^(s·D), 2·2^(s·D) and so on, counted from reset from 0. A stage never advances in a cycle where the stage before it does not advance.
- R7: Over the first 4·2^(s·D) enabled clocks after reset, each source of stage s occupies each position exactly 2^(s·D) times, counted after each clock.
- R8: Reset takes priority over `en`: a reset edge with `en` high still yields the identity mapping in all stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running interchange clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Rotation enable; low freezes the mapping |
| sel_o | output | NUM_STAGES*16 | Per-stage one-hot select matrices, bit s*16+src*4+pos |

## Verification
The bench builds two copies of the block, each with three stages. One uses `DIV_LOG2` = 0, so all stages share a phase. The other uses `DIV_LOG2` = 1, so the last stage's period grows to sixteen clocks. The occupancy count can then cover every stage's full period in a short run. The divided copy also exercises the ceiling-style advance timing of the slower stages, their behaviour during a freeze, and their return to identity on a mid-run reset.

// File: rtl/dem_pkg.sv
// Shared types and helpers for the rotation controller.
// Assumes a fixed group of four sources per divider stage.
package dem_pkg;
    localparam int unsigned NSRC  = 4;
    localparam int unsigned MAT_W = NSRC * NSRC;

    typedef logic [NSRC-1:0]  ring_t;
    typedef logic [MAT_W-1:0] xmat_t;

    // One-hot state 0 and its matrix (source i on position i)
    localparam ring_t RING_INIT  = 4'b0001;
    localparam xmat_t IDENT_XMAT = 16'h8421;

    // Width of the shared rate counter; never below one bit
    function automatic int unsigned cnt_width(input int unsigned stages,
                                              input int unsigned dlog2);
        int unsigned w;
        w = (stages - 1) * dlog2;
        return (w == 0) ? 1 : w;
    endfunction

    // Move every source one position up, wrapping 3 -> 0
    function automatic xmat_t rotate_xmat(input xmat_t m);
        xmat_t r;
        for (int src = 0; src < NSRC; src++) begin
            r[src*NSRC +: NSRC] = {m[src*NSRC + NSRC-2 -: NSRC-1],
                                   m[src*NSRC + NSRC-1]};
        end
        return r;
    endfunction
endpackage

// File: rtl/dem_tick_gen.sv
// Advance-strobe generator. Stage s is strobed on enabled clocks where
// the low s*DIV_LOG2 bits of a shared counter are zero. Stage 0 is
// strobed on every enabled clock. Assumes the counter wraps at a multiple
// of every stage's divide ratio, which holds by its width.
module dem_tick_gen #(
    parameter int unsigned NUM_STAGES = 3,
    parameter int unsigned DIV_LOG2   = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    output logic [NUM_STAGES-1:0] tick_o
);
    localparam int unsigned CNT_W = dem_pkg::cnt_width(NUM_STAGES, DIV_LOG2);

    logic [CNT_W-1:0] cnt_q;

    // Count enabled clocks since reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_tick
        localparam logic [CNT_W-1:0] MASK =
            CNT_W'((64'd1 << (s * DIV_LOG2)) - 64'd1);
        // Strobe stage s when its divide window starts
        always_comb begin
            tick_o[s] = en && ((cnt_q & MASK) == '0);
        end
    end
endmodule

// File: rtl/dem_ring_stage.sv
// Four-bit circular one-hot shift register: the rotation state of one
// divider stage. Assumes adv_i is a single-cycle strobe.
module dem_ring_stage (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv_i,
    output dem_pkg::ring_t ring_o
);
    dem_pkg::ring_t ring_q;

    // Reset to state 0, rotate left by one per strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_q <= dem_pkg::RING_INIT;
        end else if (adv_i) begin
            ring_q <= {ring_q[dem_pkg::NSRC-2:0], ring_q[dem_pkg::NSRC-1]};
        end
    end

    assign ring_o = ring_q;
endmodule

// File: rtl/dem_xbar.sv
// Decodes a one-hot rotation state into a 4x4 select matrix. Position
// pos takes source src when state (pos - src) mod 4 is active. Assumes
// ring_i is one-hot.
module dem_xbar (
    input  dem_pkg::ring_t ring_i,
    output dem_pkg::xmat_t sel_o
);
    localparam int unsigned N = dem_pkg::NSRC;

    for (genvar src = 0; src < N; src++) begin : g_src
        for (genvar pos = 0; pos < N; pos++) begin : g_pos
            localparam int unsigned K = (pos + N - src) % N;
            // Route one source/position pair
            always_comb begin
                sel_o[src*N + pos] = ring_i[K];
            end
        end
    end
endmodule

// File: rtl/dem_rotation_ctrl.sv
// Top of the rotation controller. It holds one ring register and one
// crossbar decoder per cascaded stage, and a shared advance-strobe
// generator. Runs only on the free-running interchange clock.
module dem_rotation_ctrl #(
    parameter int unsigned NUM_STAGES = 3,
    parameter int unsigned DIV_LOG2   = 0
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                en,
    output logic [NUM_STAGES*dem_pkg::MAT_W-1:0] sel_o
);
    localparam int unsigned MW = dem_pkg::MAT_W;

    logic [NUM_STAGES-1:0] tick;

    dem_tick_gen #(
        .NUM_STAGES(NUM_STAGES),
        .DIV_LOG2  (DIV_LOG2)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .tick_o(tick)
    );

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
        dem_pkg::ring_t ring;
        dem_pkg::xmat_t mat;

        dem_ring_stage u_ring (
            .clk   (clk),
            .rst_n (rst_n),
            .adv_i (tick[s]),
            .ring_o(ring)
        );

        dem_xbar u_xbar (
            .ring_i(ring),
            .sel_o (mat)
        );

        assign sel_o[s*MW +: MW] = mat;
    end
endmodule

// File: rtl/dem_rotation_chk.sv
// Property checker for the rotation controller. It only observes the
// ports. It is attached to every instance by the bind below.
module dem_rotation_chk #(
    parameter int unsigned NUM_STAGES = 3,
    parameter int unsigned DIV_LOG2   = 0
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                en,
    input logic [NUM_STAGES*dem_pkg::MAT_W-1:0] sel_o
);
    localparam int unsigned MW = dem_pkg::MAT_W;
    localparam int unsigned N  = dem_pkg::NSRC;

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_s
        // R1
        reset_ident_chk: assert property (@(posedge clk)
            !rst_n |=> sel_o[s*MW +: MW] == dem_pkg::IDENT_XMAT);

        // R4
        hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !en |=> $stable(sel_o[s*MW +: MW]));

        for (genvar i = 0; i < N; i++) begin : g_i
            logic [N-1:0] col;
            assign col = {sel_o[s*MW + 3*N + i], sel_o[s*MW + 2*N + i],
                          sel_o[s*MW + N + i],   sel_o[s*MW + i]};
            // R2
            row_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $countones(sel_o[s*MW + i*N +: N]) == 1);
            // R2
            col_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $countones(col) == 1);
        end

        if (s > 0) begin : g_chain
            // R6
            chain_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !$stable(sel_o[s*MW +: MW]) |-> !$stable(sel_o[(s-1)*MW +: MW]));
            if (DIV_LOG2 == 0) begin : g_shared
                // R5
                shared_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    sel_o[s*MW +: MW] == sel_o[0 +: MW]);
            end
        end
    end

    // R3
    first_stage_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> sel_o[0 +: MW] == dem_pkg::rotate_xmat($past(sel_o[0 +: MW])));
endmodule

bind dem_rotation_ctrl dem_rotation_chk #(
    .NUM_STAGES(NUM_STAGES),
    .DIV_LOG2  (DIV_LOG2)
) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (en),
    .sel_o(sel_o)
);

// File: tb/sim_dem_rotation_ctrl.sv
// Directed bench for the rotation controller: a shared-phase copy (u0)
// and a divided-rate copy (u1).
module sim_dem_rotation_ctrl;
    localparam int NS = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [NS*16-1:0] sel0;
    logic [NS*16-1:0] sel1;

    int checks = 0;
    int fails = 0;
    int nen = 0;    // enabled edges since last reset
    bit done = 1'b0;

    always #5 clk = ~clk;

    dem_rotation_ctrl #(.NUM_STAGES(NS), .DIV_LOG2(0)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .sel_o(sel0));
    dem_rotation_ctrl #(.NUM_STAGES(NS), .DIV_LOG2(1)) u1 (
        .clk(clk), .rst_n(rst_n), .en(en), .sel_o(sel1));

    // Expected matrix for state k: source i on position (i+k) mod 4
    function automatic logic [15:0] exp_mat(input int k);
        logic [15:0] m = '0;
        for (int src = 0; src < 4; src++) m[src*4 + ((src + k) % 4)] = 1'b1;
        return m;
    endfunction

    // Expected state of stage s after n enabled edges, divide log d
    function automatic int exp_state(input int n, input int s, input int d);
        int m = 1 << (s * d);
        return ((n + m - 1) / m) % 4;
    endfunction

    function automatic bit is_perm(input logic [15:0] m);
        for (int i = 0; i < 4; i++) begin
            if ($countones(m[i*4 +: 4]) != 1) return 1'b0;
            if ($countones({m[12+i], m[8+i], m[4+i], m[i]}) != 1) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [15:0] act, input logic [15:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Compare every stage of both copies with the model
    task automatic check_all(input string req);
        for (int s = 0; s < NS; s++) begin
            check(sel0[s*16 +: 16] == exp_mat(exp_state(nen, s, 0)),
                  {req, " u0"}, sel0[s*16 +: 16], exp_mat(exp_state(nen, s, 0)));
            check(sel1[s*16 +: 16] == exp_mat(exp_state(nen, s, 1)),
                  {req, " u1"}, sel1[s*16 +: 16], exp_mat(exp_state(nen, s, 1)));
            check(is_perm(sel0[s*16 +: 16]) && is_perm(sel1[s*16 +: 16]),
                  "R2 permutation", sel1[s*16 +: 16], 16'h0);
        end
    endtask

    task automatic do_reset(input bit en_val);
        @(negedge clk); rst_n = 1'b0; en = en_val;
        @(negedge clk); @(negedge clk);
        nen = 0;
        rst_n = 1'b1; en = 1'b0;
    endtask

    task automatic t_reset;
        do_reset(1'b0);
        check_all("R1 reset identity");
    endtask

    task automatic t_rotate(input int n);
        for (int c = 0; c < n; c++) begin
            en = 1'b1;
            @(negedge clk);
            nen++;
            check_all("R3 R5 R6 rotation step");
        end
        en = 1'b0;
    endtask

    task automatic t_freeze;
        logic [NS*16-1:0] h0, h1;
        h0 = sel0; h1 = sel1;
        en = 1'b0;
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            check(sel0 == h0 && sel1 == h1, "R4 frozen", sel1[47:32], h1[47:32]);
        end
        check_all("R4 state after freeze");
    endtask

    task automatic t_occupancy;
        int occ0 [NS][4][4];
        int occ1 [NS][4][4];
        do_reset(1'b0);
        foreach (occ0[s, i, p]) begin occ0[s][i][p] = 0; occ1[s][i][p] = 0; end
        for (int c = 0; c < 16; c++) begin
            en = 1'b1;
            @(negedge clk);
            nen++;
            for (int s = 0; s < NS; s++)
                for (int i = 0; i < 4; i++)
                    for (int p = 0; p < 4; p++) begin
                        occ0[s][i][p] += int'(sel0[s*16 + i*4 + p]);
                        occ1[s][i][p] += int'(sel1[s*16 + i*4 + p]);
                    end
        end
        en = 1'b0;
        for (int s = 0; s < NS; s++)
            for (int i = 0; i < 4; i++)
                for (int p = 0; p < 4; p++) begin
                    check(occ0[s][i][p] == 4, "R7 occupancy u0",
                          16'(occ0[s][i][p]), 16'd4);
                    check(occ1[s][i][p] == 4, "R7 occupancy u1",
                          16'(occ1[s][i][p]), 16'd4);
                end
    endtask

    task automatic t_midreset;
        t_rotate(7);
        do_reset(1'b1);
        check_all("R8 reset over enable");
    endtask

    initial begin
        t_reset();
        t_rotate(9);
        t_freeze();
        t_rotate(6);
        t_freeze();
        t_occupancy();
        t_midreset();
        t_rotate(3);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule